// File: doc/BRIEF.md
# Streaming-Hint Cache Set Allocator

This block manages one set of a set-associative L1 data cache. It holds the tag and per-way line flags (valid, dirty, unique, transient, non-temporal). For every request it decides one of three outcomes. On a hit it reports the matching way. On a miss that must be kept out of L1 it reports that the line goes only to L2. On any other miss it picks a victim way, installs the new line and reports what happens to the line that was displaced. The data arrays and the linefill protocol sit outside the block.

Two kinds of streaming hint change the allocation policy. A transient load still fills L1, but the line is flagged. A non-temporal load also fills L1, and it is flagged only when the line arrives held unique. Such a line is then the preferred victim for later fills. When a flagged line is evicted, it is never written into L2. A clean flagged line is simply dropped, and a dirty one is written back past L2. A streaming store that misses is not allocated in L1 at all.

Requests arrive on a valid/ready channel and results leave on a second valid/ready channel. The response stage is a single register. A request is accepted when `req_valid` and `req_ready` are both high. Its result appears in `rsp_valid` in the next cycle. `req_ready` is high exactly when no response is pending or the pending one is being taken in the same cycle. A response that is not taken keeps every payload field unchanged. Back-pressure on the response side therefore stalls the request side directly, with no extra buffering.

Top module: `streamhint_set_ctrl`

## Requirements
- R1: After reset every way is invalid, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge yields exactly one response, with `rsp_valid` high from the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is 0 and every response field holds its value.
- R3: A tag match in a valid way gives `rsp_hit`=1 with that way in `rsp_way`, `rsp_place_l1`=1 and `rsp_evict`=0 (none). A hit changes no flag, except that a store hit sets the line's dirty flag.
- R4: A miss with the normal hint (`req_hint`=0) allocates in L1 (`rsp_place_l1`=1). The new line is dirty when the request is a store.
- R5: Victim order on an allocating miss has three steps. First comes the lowest-numbered valid way holding the non-temporal mark. Next comes the lowest-numbered invalid way. Last comes a round-robin pointer, which starts at way 0 and advances by one, wrapping, only when it supplies the victim.
- R6: A load miss with the transient hint (`req_hint`=1) allocates in L1 with the transient flag set, whatever the unique state.
- R7: A clean victim carrying the transient or non-temporal flag gives `rsp_evict`=3 (drop, no L2 allocation) with `rsp_victim_dirty`=0.
- R8: A dirty victim carrying the transient or non-temporal flag gives `rsp_evict`=2 (write back past L2) with `rsp_victim_dirty`=1.
- R9: An unflagged valid victim gives `rsp_evict`=1 (allocate into L2), with `rsp_victim_dirty` equal to its dirty flag and `rsp_victim_tag` equal to its tag.
- R10: A store miss with the transient or non-temporal hint (1 or 2) gives `rsp_place_l1`=0, `rsp_hit`=0 and `rsp_evict`=0, and leaves the set unchanged.
- R11: A load miss with the non-temporal hint (`req_hint`=2) sets the non-temporal mark only when `req_unique`=1. A shared line is installed as a normal line.
- R12: An invalid victim way gives `rsp_evict`=0, `rsp_victim_dirty`=0 and `rsp_victim_tag`=0. Hits and L2-only stores also report tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_tag | input | TAG_W | Line tag of the access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_hint | input | 2 | 0 normal, 1 transient, 2 non-temporal, 3 treated as normal |
| req_unique | input | 1 | Returned line held unique (1) or shared (0) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Access hit in the set |
| rsp_way | output | $clog2(WAYS) | Hit way or allocated way (0 for an L2-only store) |
| rsp_place_l1 | output | 1 | Line resides in L1 after the access |
| rsp_evict | output | 2 | 0 none, 1 to L2, 2 write back past L2, 3 drop |
| rsp_victim_dirty | output | 1 | Displaced line was dirty |
| rsp_victim_tag | output | TAG_W | Tag of the displaced line |

## Verification
The bench builds the block with WAYS=4 and TAG_W=12. Four ways are few enough that short sequences fill the set, wrap the round-robin pointer and make a flagged line win over the pointer. A 12-bit tag keeps hits and misses easy to steer. The response consumer stalls on a fixed pattern, so the hold behaviour and request blocking are exercised while hint-driven evictions are in flight. A seeded pseudo-random phase, using a small tag pool, mixes every hint with both access types and both unique states.

// File: rtl/shset_pkg.sv
package shset_pkg;

  typedef enum logic [1:0] {
    HINT_NORMAL    = 2'd0,
    HINT_TRANSIENT = 2'd1,
    HINT_NONTEMP   = 2'd2,
    HINT_SPARE     = 2'd3
  } hint_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_TO_L2  = 2'd1,
    EV_BYPASS = 2'd2,
    EV_DROP   = 2'd3
  } evict_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic uniq;
    logic transient;
    logic nontemp;
  } wflags_t;

endpackage

// File: rtl/shset_lookup.sv
module shset_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid_vec,
  input  logic [WAYS*TAG_W-1:0] tag_flat,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid_vec[w] && (tag_flat[w*TAG_W +: TAG_W] == look_tag);
    end
  endgenerate

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/shset_victim.sv
module shset_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAYS-1:0]  nt_vec,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim_way,
  output logic             use_rr
);
  logic             nt_found, inv_found;
  logic [WAY_W-1:0] nt_way, inv_way;

  always_comb begin
    nt_found  = 1'b0;
    inv_found = 1'b0;
    nt_way    = '0;
    inv_way   = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (valid_vec[w] && nt_vec[w]) begin
        nt_found = 1'b1;
        nt_way   = WAY_W'(w);
      end
      if (!valid_vec[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
    use_rr = !nt_found && !inv_found;
    if (nt_found)       victim_way = nt_way;
    else if (inv_found) victim_way = inv_way;
    else                victim_way = rr_ptr;
  end
endmodule

// File: rtl/shset_evict.sv
module shset_evict
  import shset_pkg::*;
(
  input  wflags_t    vic_fl,
  output logic [1:0] act,
  output logic       vic_dirty
);
  evict_e act_e;

  always_comb begin
    act_e     = EV_NONE;
    vic_dirty = 1'b0;
    if (vic_fl.valid) begin
      vic_dirty = vic_fl.dirty;
      if (vic_fl.transient || vic_fl.nontemp)
        act_e = vic_fl.dirty ? EV_BYPASS : EV_DROP;
      else
        act_e = EV_TO_L2;
    end
  end

  assign act = act_e;
endmodule

// File: rtl/streamhint_set_ctrl.sv
module streamhint_set_ctrl
  import shset_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_store,
  input  logic [1:0]       req_hint,
  input  logic             req_unique,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic             rsp_place_l1,
  output logic [1:0]       rsp_evict,
  output logic             rsp_victim_dirty,
  output logic [TAG_W-1:0] rsp_victim_tag
);
  // Per-way line state
  wflags_t          fl_q  [WAYS];
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAY_W-1:0] rr_q;

  logic [WAYS-1:0]       valid_vec, nt_vec;
  logic [WAYS*TAG_W-1:0] tag_flat;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_pack
      assign valid_vec[w]                  = fl_q[w].valid;
      assign nt_vec[w]                     = fl_q[w].nontemp;
      assign tag_flat[w*TAG_W +: TAG_W]    = tag_q[w];
    end
  endgenerate

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vic_way;
  logic             use_rr;
  logic [1:0]       ev_act;
  logic             ev_dirty;
  wflags_t          vic_fl;

  shset_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .valid_vec (valid_vec),
    .tag_flat  (tag_flat),
    .look_tag  (req_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  shset_victim #(.WAYS(WAYS)) u_victim (
    .valid_vec  (valid_vec),
    .nt_vec     (nt_vec),
    .rr_ptr     (rr_q),
    .victim_way (vic_way),
    .use_rr     (use_rr)
  );

  assign vic_fl = fl_q[vic_way];

  shset_evict u_evict (
    .vic_fl    (vic_fl),
    .act       (ev_act),
    .vic_dirty (ev_dirty)
  );

  // Request decode
  hint_e   hint;
  logic    streaming, stream_store, accept, alloc;
  wflags_t new_fl;

  assign hint         = hint_e'(req_hint);
  assign streaming    = (hint == HINT_TRANSIENT) || (hint == HINT_NONTEMP);
  assign stream_store = req_store && streaming;
  assign req_ready    = !rsp_valid || rsp_ready;
  assign accept       = req_valid && req_ready;
  assign alloc        = accept && !hit && !stream_store;

  always_comb begin
    new_fl.valid     = 1'b1;
    new_fl.dirty     = req_store;
    new_fl.uniq      = req_unique;
    new_fl.transient = (hint == HINT_TRANSIENT);
    new_fl.nontemp   = (hint == HINT_NONTEMP) && req_unique;
  end

  // Flag and pointer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) fl_q[w] <= '0;
      rr_q <= '0;
    end else if (accept) begin
      if (hit) begin
        if (req_store) fl_q[hit_way].dirty <= 1'b1;
      end else if (alloc) begin
        fl_q[vic_way] <= new_fl;
        if (use_rr) rr_q <= (rr_q == WAY_W'(WAYS-1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[vic_way] <= req_tag;
  end

  // Response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid        <= 1'b0;
      rsp_hit          <= 1'b0;
      rsp_way          <= '0;
      rsp_place_l1     <= 1'b0;
      rsp_evict        <= EV_NONE;
      rsp_victim_dirty <= 1'b0;
      rsp_victim_tag   <= '0;
    end else if (accept) begin
      rsp_valid        <= 1'b1;
      rsp_hit          <= hit;
      rsp_place_l1     <= hit || !stream_store;
      rsp_way          <= hit ? hit_way : (alloc ? vic_way : '0);
      rsp_evict        <= alloc ? ev_act : EV_NONE;
      rsp_victim_dirty <= alloc && ev_dirty;
      rsp_victim_tag   <= (alloc && vic_fl.valid) ? tag_q[vic_way] : '0;
    end else if (rsp_ready) begin
      rsp_valid        <= 1'b0;
    end
  end
endmodule

// File: rtl/shset_checker.sv
module shset_checker #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_place_l1,
  input logic [1:0]       rsp_evict,
  input logic             rsp_victim_dirty,
  input logic [TAG_W-1:0] rsp_victim_tag
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_hit, rsp_way, rsp_place_l1,
                                    rsp_evict, rsp_victim_dirty, rsp_victim_tag})));

  assert_rsp_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  assert_hit_no_evict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_evict == 2'd0 && rsp_place_l1));

  assert_drop_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict == 2'd3) |-> !rsp_victim_dirty);

  assert_bypass_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict == 2'd2) |-> rsp_victim_dirty);

  assert_l2_only_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_place_l1) |-> (!rsp_hit && rsp_evict == 2'd0));

  assert_none_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict == 2'd0) |-> (!rsp_victim_dirty && rsp_victim_tag == '0));
endmodule

bind streamhint_set_ctrl shset_checker #(.WAYS(WAYS), .TAG_W(TAG_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_hit          (rsp_hit),
  .rsp_way          (rsp_way),
  .rsp_place_l1     (rsp_place_l1),
  .rsp_evict        (rsp_evict),
  .rsp_victim_dirty (rsp_victim_dirty),
  .rsp_victim_tag   (rsp_victim_tag)
);

// File: tb/tb_streamhint_set_ctrl.sv
module tb_streamhint_set_ctrl;
  localparam int  WAYS       = 4;
  localparam int  TAG_W      = 12;
  localparam int  WAY_W      = $clog2(WAYS);
  localparam time CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_ready, req_store, req_unique;
  logic [TAG_W-1:0] req_tag;
  logic [1:0]       req_hint;
  logic             rsp_valid, rsp_ready, rsp_hit, rsp_place_l1, rsp_victim_dirty;
  logic [WAY_W-1:0] rsp_way;
  logic [1:0]       rsp_evict;
  logic [TAG_W-1:0] rsp_victim_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  streamhint_set_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .req_store(req_store), .req_hint(req_hint), .req_unique(req_unique),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_place_l1(rsp_place_l1), .rsp_evict(rsp_evict),
    .rsp_victim_dirty(rsp_victim_dirty), .rsp_victim_tag(rsp_victim_tag)
  );

  typedef struct packed {
    logic             hit;
    logic [WAY_W-1:0] way;
    logic             l1;
    logic [1:0]       ev;
    logic             vd;
    logic [TAG_W-1:0] vtag;
  } exp_t;

  exp_t  expq [$];
  string rqq  [$];
  int    n_chk  = 0;
  int    n_fail = 0;

  // Reference model of the set, written from the requirements
  bit               m_v [WAYS];
  bit               m_d [WAYS];
  bit               m_t [WAYS];
  bit               m_n [WAYS];
  logic [TAG_W-1:0] m_tag [WAYS];
  int               m_rr = 0;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send(input logic [TAG_W-1:0] t, input bit st, input logic [1:0] h,
                      input bit u, input string rq);
    exp_t e;
    int   hw;
    int   v;
    bit   strm;
    e    = '0;
    hw   = -1;
    v    = -1;
    strm = (h == 2'd1) || (h == 2'd2);
    for (int w = 0; w < WAYS; w++)
      if (hw < 0 && m_v[w] && m_tag[w] == t) hw = w;
    if (hw >= 0) begin
      e.hit = 1'b1;
      e.way = WAY_W'(hw);
      e.l1  = 1'b1;
      if (st) m_d[hw] = 1'b1;
    end else if (st && strm) begin
      e.l1 = 1'b0;
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (v < 0 && m_v[w] && m_n[w]) v = w;
      for (int w = 0; w < WAYS; w++)
        if (v < 0 && !m_v[w]) v = w;
      if (v < 0) begin
        v    = m_rr;
        m_rr = (m_rr + 1) % WAYS;
      end
      e.way = WAY_W'(v);
      e.l1  = 1'b1;
      if (m_v[v]) begin
        e.vtag = m_tag[v];
        e.vd   = m_d[v];
        if (m_t[v] || m_n[v]) e.ev = m_d[v] ? 2'd2 : 2'd3;
        else                  e.ev = 2'd1;
      end
      m_v[v]   = 1'b1;
      m_d[v]   = st;
      m_t[v]   = (h == 2'd1);
      m_n[v]   = (h == 2'd2) && u;
      m_tag[v] = t;
    end
    expq.push_back(e);
    rqq.push_back(rq);
    req_tag    = t;
    req_store  = st;
    req_hint   = h;
    req_unique = u;
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  // Response consumer: stalls on a fixed pattern, changes away from the edge
  int cyc = 0;
  initial begin
    rsp_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      rsp_ready = (cyc % 5) != 3 && (cyc % 7) != 0;
    end
  end

  // Monitor / scoreboard
  exp_t  m_e, m_got;
  string m_rq;
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_fail++;
        $display("FAIL R2: response with no request outstanding (actual 1, expected 0)");
      end else begin
        m_e   = expq.pop_front();
        m_rq  = rqq.pop_front();
        m_got = '{rsp_hit, rsp_way, rsp_place_l1, rsp_evict, rsp_victim_dirty, rsp_victim_tag};
        if (m_got !== m_e) begin
          n_fail++;
          $display("FAIL %s: actual hit=%0d way=%0d l1=%0d ev=%0d vd=%0d vtag=%0h expected hit=%0d way=%0d l1=%0d ev=%0d vd=%0d vtag=%0h",
                   m_rq, m_got.hit, m_got.way, m_got.l1, m_got.ev, m_got.vd, m_got.vtag,
                   m_e.hit, m_e.way, m_e.l1, m_e.ev, m_e.vd, m_e.vtag);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  logic [15:0] lfsr;
  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_tag    = '0;
    req_store  = 1'b0;
    req_hint   = 2'd0;
    req_unique = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: actual rsp_valid=%0b req_ready=%0b expected 0 1", rsp_valid, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Fill through invalid ways (R12, R4, R5)
    send(12'hA01, 0, 2'd0, 1, "R12 fill way0");
    send(12'hA02, 0, 2'd0, 1, "R12 fill way1");
    send(12'hA03, 1, 2'd0, 1, "R4 store miss fill way2 dirty");
    send(12'hA04, 0, 2'd0, 1, "R4 fill way3");
    send(12'hA01, 0, 2'd0, 1, "R3 load hit");
    send(12'hA02, 1, 2'd0, 1, "R3 store hit sets dirty");
    send(12'hB01, 0, 2'd0, 1, "R9 clean normal victim rr way0");
    send(12'hB02, 0, 2'd0, 1, "R9 dirty normal victim way1");
    send(12'hB03, 0, 2'd2, 1, "R11 unique nontemporal load");
    send(12'hB04, 0, 2'd0, 1, "R7 R5 nontemporal way preferred and dropped");
    send(12'hB05, 0, 2'd2, 0, "R11 shared nontemporal load");
    send(12'hB06, 0, 2'd0, 1, "R5 round robin wraps");
    send(12'hB07, 0, 2'd1, 0, "R6 transient load allocates");
    send(12'hB07, 1, 2'd0, 1, "R3 store hit on transient line");
    send(12'hC01, 1, 2'd1, 1, "R10 transient store miss");
    send(12'hC02, 1, 2'd2, 1, "R10 nontemporal store miss");
    send(12'hC01, 0, 2'd0, 1, "R10 line absent after streaming store");
    send(12'hC03, 0, 2'd0, 1, "R11 shared line evicted to L2");
    send(12'hC04, 0, 2'd0, 1, "R5 round robin");
    send(12'hC05, 0, 2'd0, 1, "R8 dirty transient victim bypass");
    send(12'hC06, 0, 2'd2, 1, "R11 unique nontemporal load");
    send(12'hC06, 1, 2'd0, 1, "R3 store hit keeps nontemporal mark");
    send(12'hC07, 0, 2'd0, 1, "R8 dirty nontemporal victim bypass");
    send(12'hC08, 0, 2'd1, 1, "R6 transient load");
    send(12'hC09, 0, 2'd3, 1, "R4 spare hint treated normal");

    // Pseudo-random mix over a small tag pool (R5)
    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(TAG_W'(12'hD00 + lfsr[2:0]), lfsr[3], lfsr[5:4], lfsr[6], "R5 mixed traffic");
    end

    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule